// File: doc/BRIEF.md
# Root Hub Register Window

This block is the register window for the root hub of a USB host controller. It decodes 32-bit word-aligned reads and writes from a simple request port. The register index is the byte address shifted right by two. The block holds two hub descriptor registers, the hub status and command register, and one port status register for each downstream port. The port count `NUM_PORTS` is a parameter, so it is fixed from reset onward. The readable window ends right after the last configured port register, so its size tracks the port count.

Software controls port power in two ways. It can write a global power command to the hub status register, or it can write per-port set and clear commands to a port status register. Global commands act only on the configured ports. Descriptor A always reports the configured port count, and software writes cannot change that count or the device-type bit. Any access outside the window is rejected: reads return all ones and writes do nothing.

Top module: `rh_reg_window`

## Requirements
- R1: `NUM_PORTS` may be 1 to 15, with a default of 12. Bits [7:0] of descriptor A always read back `NUM_PORTS`.
- R2: The register index is `addr_i >> 2`. Descriptor A is at index 18, descriptor B at index 19 and hub status at index 20. The status register of port k (0-based) is at index 21+k.
- R3: The window holds 21+`NUM_PORTS` registers. A read at any index at or beyond that count returns 0xFFFFFFFF. A write there changes no register and no port power bit.
- R4: A write to descriptor A leaves bits [7:0] and bit 10 (device type, always read as 0) unchanged. Bits 8 (switching mode), 9 (no switching) and [31:24] store the written value. All other bits read as 0.
- R5: Reset sets descriptor A to 0x200 | `NUM_PORTS`, sets descriptor B to 0 and turns every port's power off. Hub status reads 0 after reset.
- R6: Writing a 1 to bit 16 of hub status powers up every configured port. Writing a 1 to bit 0 powers every configured port down. When both bits are 1, power-up wins. Hub status always reads 0.
- R7: Bit 8 of a port status register reads back that port's power state. Writing a 1 to bit 8 powers the port up, and writing a 1 to bit 9 powers it down (bit 8 wins if both are 1). No other port changes. Other port bits read as 0.
- R8: Read data is registered and appears on the cycle after the request. It holds until the next read, and writes and idle cycles do not change it.
- R9: Descriptor B stores all 32 written bits.
- R10: Indices 0 to 17 lie inside the window but read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address from the block base |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| port_pwr_o | output | NUM_PORTS | Power state of each port |

## Verification
The assertions check the following on every cycle:
- Descriptor A reads return the fixed port count and a zero device-type bit.
- Reads outside the window return all ones.
- Writes outside the window leave port power stable.
- Global power commands drive every configured port in the next cycle.

Some behaviour only the bench scenarios can show. These are the full index map under sweeps, correction of descriptor A after a write, per-port power isolation, the priority when set and clear arrive together, and read data holding across writes.

// File: rtl/rh_reg_pkg.sv
package rh_reg_pkg;
  localparam int MAX_PORTS     = 15;
  localparam int IDX_DESC_A    = 18;
  localparam int IDX_DESC_B    = 19;
  localparam int IDX_HUB_STAT  = 20;
  localparam int IDX_PORT_BASE = 21;
  localparam logic [31:0] DA_WR_MASK = 32'hFF00_0300;
  localparam logic [31:0] DA_RST_VAL = 32'h0000_0200;
  localparam int HS_CLR_GPWR = 0;
  localparam int HS_SET_GPWR = 16;
  localparam int PS_PWR      = 8;
  localparam int PS_CLR_PWR  = 9;
endpackage

// File: rtl/rh_decode.sv
module rh_decode #(
  parameter int NUM_PORTS = 12,
  parameter int ADDR_W    = 8,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 in_win_o,
  output logic                 rd_o,
  output logic                 wr_a_o,
  output logic                 wr_b_o,
  output logic                 wr_hub_o,
  output logic [NUM_PORTS-1:0] port_wr_o
);
  import rh_reg_pkg::*;
  localparam int VALID_REGS = IDX_PORT_BASE + NUM_PORTS;

  logic unused_lsb;
  logic wr_ok;

  assign unused_lsb = ^addr_i[1:0];
  assign idx_o      = addr_i[ADDR_W-1:2];
  assign in_win_o   = idx_o < IDX_W'(VALID_REGS);
  assign rd_o       = req_i && !we_i;
  assign wr_ok      = req_i && we_i && in_win_o;
  assign wr_a_o     = wr_ok && (idx_o == IDX_W'(IDX_DESC_A));
  assign wr_b_o     = wr_ok && (idx_o == IDX_W'(IDX_DESC_B));
  assign wr_hub_o   = wr_ok && (idx_o == IDX_W'(IDX_HUB_STAT));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port_sel
    assign port_wr_o[k] = wr_ok && (idx_o == IDX_W'(IDX_PORT_BASE + k));
  end
endmodule

// File: rtl/rh_desc_regs.sv
module rh_desc_regs #(
  parameter int NUM_PORTS = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_a_i,
  input  logic        wr_b_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] desc_a_o,
  output logic [31:0] desc_b_o
);
  import rh_reg_pkg::*;

  logic [31:0] a_q, b_q;

  // only the writable fields are stored; port count is merged on read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= DA_RST_VAL;
      b_q <= '0;
    end else begin
      if (wr_a_i) a_q <= wdata_i & DA_WR_MASK;
      if (wr_b_i) b_q <= wdata_i;
    end
  end

  assign desc_a_o = a_q | {24'h0, 8'(NUM_PORTS)};
  assign desc_b_o = b_q;
endmodule

// File: rtl/rh_port_power.sv
module rh_port_power #(
  parameter int NUM_PORTS = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 gset_i,
  input  logic                 gclr_i,
  input  logic [NUM_PORTS-1:0] port_wr_i,
  input  logic                 pset_i,
  input  logic                 pclr_i,
  output logic [NUM_PORTS-1:0] pwr_o
);
  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    logic on_q;
    logic set_c, clr_c;
    assign set_c = gset_i || (port_wr_i[k] && pset_i);
    assign clr_c = gclr_i || (port_wr_i[k] && pclr_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    on_q <= 1'b0;
      else if (set_c) on_q <= 1'b1;
      else if (clr_c) on_q <= 1'b0;
    end
    assign pwr_o[k] = on_q;
  end
endmodule

// File: rtl/rh_reg_window.sv
module rh_reg_window #(
  parameter int NUM_PORTS = 12,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_PORTS-1:0] port_pwr_o
);
  import rh_reg_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     idx;
  logic                 in_win, rd, wr_a, wr_b, wr_hub;
  logic [NUM_PORTS-1:0] port_wr;
  logic [31:0]          desc_a, desc_b, rd_val, rdata_q;

  rh_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .idx_o(idx), .in_win_o(in_win), .rd_o(rd),
    .wr_a_o(wr_a), .wr_b_o(wr_b), .wr_hub_o(wr_hub), .port_wr_o(port_wr)
  );

  rh_desc_regs #(.NUM_PORTS(NUM_PORTS)) u_desc (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_a_i(wr_a), .wr_b_i(wr_b),
    .wdata_i(wdata_i), .desc_a_o(desc_a), .desc_b_o(desc_b)
  );

  rh_port_power #(.NUM_PORTS(NUM_PORTS)) u_pwr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .gset_i(wr_hub && wdata_i[HS_SET_GPWR]),
    .gclr_i(wr_hub && wdata_i[HS_CLR_GPWR]),
    .port_wr_i(port_wr),
    .pset_i(wdata_i[PS_PWR]), .pclr_i(wdata_i[PS_CLR_PWR]),
    .pwr_o(port_pwr_o)
  );

  always_comb begin
    rd_val = '0;
    if (!in_win)                            rd_val = '1;
    else if (idx == IDX_W'(IDX_DESC_A))     rd_val = desc_a;
    else if (idx == IDX_W'(IDX_DESC_B))     rd_val = desc_b;
    for (int k = 0; k < NUM_PORTS; k++)
      if (in_win && idx == IDX_W'(IDX_PORT_BASE + k)) rd_val[PS_PWR] = port_pwr_o[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rh_reg_window_chk.sv
module rh_reg_window_chk #(
  parameter int NUM_PORTS = 12,
  parameter int ADDR_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [31:0]          wdata_i,
  input logic [31:0]          rdata_o,
  input logic [NUM_PORTS-1:0] port_pwr_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int VALID = 21 + NUM_PORTS;

  logic [IDX_W-1:0] idx;
  logic unused_chk;
  assign idx = addr_i[ADDR_W-1:2];
  assign unused_chk = ^{addr_i[1:0], wdata_i[31:17], wdata_i[15:1]};

  p_ndp_fixed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && idx == IDX_W'(18) |=> rdata_o[7:0] == 8'(NUM_PORTS));

  p_oob_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && idx >= IDX_W'(VALID) |=> rdata_o == 32'hFFFF_FFFF);

  p_oob_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && idx >= IDX_W'(VALID) |=> $stable(port_pwr_o));

  p_dt_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && idx == IDX_W'(18) |=> !rdata_o[10]);

  p_gpwr_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && idx == IDX_W'(20) && wdata_i[16] |=> &port_pwr_o);

  p_gpwr_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && idx == IDX_W'(20) && wdata_i[0] && !wdata_i[16] |=> port_pwr_o == '0);

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

bind rh_reg_window rh_reg_window_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .port_pwr_o(port_pwr_o)
);

// File: tb/rh_reg_window_tb_top.sv
`timescale 1ns/1ps
module rh_reg_window_tb_top;
  localparam int N      = 3;
  localparam int ADDR_W = 8;
  localparam int NIDX   = 1 << (ADDR_W - 2);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic             we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]      wdata_i = '0;
  logic [31:0]      rdata_o;
  logic [N-1:0]     port_pwr_o;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_da = 32'h200;
  logic [31:0] m_db = 32'h0;
  logic [N-1:0] m_pwr = '0;

  always #4 clk_i = ~clk_i;

  rh_reg_window #(.NUM_PORTS(N), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .port_pwr_o(port_pwr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int idx);
    if (idx >= 21 + N) return 32'hFFFF_FFFF;
    if (idx == 18) return m_da | 32'(N);
    if (idx == 19) return m_db;
    if (idx >= 21) return {23'h0, m_pwr[idx-21], 8'h0};
    return 32'h0;
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = ADDR_W'(idx << 2); wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    if (idx < 21 + N) begin
      if (idx == 18) m_da = d & 32'hFF00_0300;
      else if (idx == 19) m_db = d;
      else if (idx == 20) begin
        if (d[16]) m_pwr = '1;
        else if (d[0]) m_pwr = '0;
      end else if (idx >= 21) begin
        if (d[8]) m_pwr[idx-21] = 1'b1;
        else if (d[9]) m_pwr[idx-21] = 1'b0;
      end
    end
  endtask

  task automatic rd(input int idx, input string tag);
    logic [31:0] e;
    e = exp_rd(idx);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = ADDR_W'(idx << 2);
    @(negedge clk_i);
    req_i = 1'b0;
    check($sformatf("%s idx=%0d", tag, idx), rdata_o, e);
  endtask

  task automatic chk_pwr(input string tag);
    check(tag, 32'(port_pwr_o), 32'(m_pwr));
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NIDX; i++) rd(i, tag);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog R8 act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk_i);
    check("R5 reset rdata", rdata_o, 32'h0);
    check("R5 reset power", 32'(port_pwr_o), 32'h0);
    rst_ni = 1'b1;
    rd(18, "R5 R1 desc A reset");
    rd(19, "R5 desc B reset");
    rd(20, "R5 hub status reset");
    sweep("R2 R3 R10 sweep after reset");

    wr(18, 32'hFFFF_FFFF);
    rd(18, "R4 desc A all ones");
    wr(18, 32'h0000_0000);
    rd(18, "R4 R1 desc A zero");
    wr(18, 32'hA5C3_04F0);
    rd(18, "R4 desc A pattern");

    wr(19, 32'hDEAD_BEEF); rd(19, "R9 desc B pattern");
    wr(19, 32'h1234_5678); rd(19, "R9 desc B pattern2");

    wr(20, 32'h0001_0000); chk_pwr("R6 global on");
    sweep("R6 R7 sweep powered");
    rd(20, "R6 hub status reads zero");
    wr(20, 32'h0000_0001); chk_pwr("R6 global off");
    wr(20, 32'h0001_0001); chk_pwr("R6 set wins");
    wr(20, 32'h0000_0001); chk_pwr("R6 off again");

    for (int k = 0; k < N; k++) begin
      wr(21 + k, 32'h0000_0100); chk_pwr("R7 port set");
      sweep("R7 R2 sweep port set");
    end
    wr(22, 32'h0000_0200); chk_pwr("R7 port clear");
    rd(22, "R7 port read off");
    wr(21, 32'h0000_0300); chk_pwr("R7 port both set wins");

    for (int i = 21 + N; i < NIDX; i++) begin
      wr(i, 32'hFFFF_FFFF);
      chk_pwr("R3 oob write no power change");
    end
    wr(21 + N, 32'h0000_0200); chk_pwr("R3 oob clear ignored");
    sweep("R3 sweep after oob writes");

    for (int i = 0; i < 18; i++) wr(i, 32'hFFFF_FFFF);
    chk_pwr("R10 low writes no power change");
    sweep("R10 sweep after low writes");

    rd(19, "R8 read before hold");
    held = rdata_o;
    wr(19, 32'h0F0F_0F0F);
    repeat (4) @(negedge clk_i);
    check("R8 rdata held", rdata_o, held);
    rd(19, "R8 R9 new read");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule